// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic unit of an 8-bit accumulator processor. Each request carries a register value (accumulator or index register), an 8-bit operand, the current carry, overflow and decimal flags, and a 4-bit operation code. The block returns an 8-bit result and new negative (N), zero (Z), carry (C) and overflow (V) flags. Operand fetch and read-modify-write sequencing belong to the surrounding core.

The request enters through a valid/ready handshake and is registered into a one-entry output stage that has its own valid/ready handshake. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs one cycle later with `out_valid` high. The output stays frozen for as long as `out_ready` is low. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-to-back operations flow at one per cycle when the consumer always accepts.

When the decimal flag is set, add and subtract treat both values as two packed BCD digits. Subtraction borrows digit by digit and subtracts 6 from any digit that went negative. In decimal mode the overflow flag is always cleared.

Top module: `alu8_stream_unit`

## Requirements
- R1: For every operation except bit test (code 6), `out_n` equals bit 7 of `out_result` and `out_z` is 1 exactly when `out_result` is zero.
- R2: After reset `out_valid` is 0 and `in_ready` is 1. A request accepted at an edge (`in_valid` and `in_ready` high) appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output and its flags hold steady and no new request is taken.
- R3: With `in_dec`=0, add (code 0) gives `reg + opnd + C`, with C the carry out of bit 7. Subtract (code 1) adds the inverted operand, so C=1 means no borrow. In both, V is set when the two added values share a sign that differs from the sign of the result.
- R4: AND (code 2), OR (code 3) and XOR (code 4) give the bitwise result. Codes 13 to 15 pass the register through unchanged. All of these pass `in_c` and `in_v` to `out_c` and `out_v`.
- R5: Shift left (code 7) and rotate left (code 9) move old bit 7 into C. Logical shift right (code 8) and rotate right (code 10) move old bit 0 into C. Rotate left places the old carry in bit 0 and rotate right places it in bit 7. The shifts fill with 0. V passes through unchanged.
- R6: Bit test (code 6) returns the register unchanged. It sets Z when `reg & opnd` is zero, and copies operand bit 7 into N and operand bit 6 into V. C passes through unchanged.
- R7: Compare (code 5) returns `(reg - opnd) mod 256`. It sets C when `reg >= opnd` (unsigned), so Z means equal and N is bit 7 of the difference. V passes through unchanged.
- R8: With `in_dec`=1, add works digit by digit from the low digit: sum = digits + carry, and 6 is added when the sum exceeds 9. The carry into the next digit, and finally C, is set when the corrected sum reaches 16.
- R9: With `in_dec`=1, subtract works digit by digit from the low digit: d = reg digit − operand digit − borrow, where the first borrow is `1 - in_c`. If bit 4 of d is set, 6 is subtracted. The borrow for the next digit is bit 4 of the corrected value, and each result digit is the low four bits. C is the binary no-borrow value (`reg >= opnd + 1 - in_c`).
- R10: In decimal mode, add and subtract always return V=0.
- R11: Increment (code 11) and decrement (code 12) wrap modulo 256 and pass C and V through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_reg | input | 8 | Register value (accumulator or index) |
| in_opnd | input | 8 | Operand |
| in_c | input | 1 | Current carry flag |
| in_v | input | 1 | Current overflow flag |
| in_dec | input | 1 | Decimal mode flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result value |
| out_n | output | 1 | New negative flag |
| out_z | output | 1 | New zero flag |
| out_c | output | 1 | New carry flag |
| out_v | output | 1 | New overflow flag |

## Verification
The hardest cases to reach are the decimal subtract corners. Here a digit borrow chains into the high digit, or a digit goes far enough negative that bit 4 clears after the −6 correction, so the borrow into the next digit does not propagate. Random operands seldom hit these with the right carry-in. The bench therefore drives directed cases such as 0x00 − 0x01 and operands that are not valid BCD. It then mixes seeded random operations, in which roughly half of all add and subtract requests run in decimal mode. A separate stall sequence holds `out_ready` low while a second request waits, to show that the held result does not change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DIGITS = 2;
  localparam int DW     = 4 * DIGITS;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12,
    OP_PS1 = 4'd13,
    OP_PS2 = 4'd14,
    OP_PS3 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          c_in,
  input  logic          dec,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          v_out
);
  logic [DW-1:0] mm;
  logic [DW:0]   bin_sum;
  logic          bin_v;
  logic [DW-1:0] dadd_res;
  logic [DW-1:0] dsub_res;
  logic          dadd_cy;

  assign mm      = sub ? ~m : m;
  assign bin_sum = {1'b0, a} + {1'b0, mm} + {{DW{1'b0}}, c_in};
  assign bin_v   = ~(a[DW-1] ^ mm[DW-1]) & (a[DW-1] ^ bin_sum[DW-1]);

  // Decimal add: per-digit carry chain with +6 fix-up
  always_comb begin
    logic [5:0] s;
    logic       cy;
    cy       = c_in;
    dadd_res = '0;
    for (int i = 0; i < DIGITS; i++) begin
      s = {2'b00, a[4*i +: 4]} + {2'b00, m[4*i +: 4]} + {5'b0, cy};
      if (s > 6'd9) s = s + 6'd6;
      dadd_res[4*i +: 4] = s[3:0];
      cy = (s >= 6'd16);
    end
    dadd_cy = cy;
  end

  // Decimal subtract: per-digit borrow chain with -6 fix-up
  always_comb begin
    logic [4:0] d;
    logic       bw;
    bw       = ~c_in;
    dsub_res = '0;
    for (int i = 0; i < DIGITS; i++) begin
      d = {1'b0, a[4*i +: 4]} - {1'b0, m[4*i +: 4]} - {4'b0, bw};
      if (d[4]) d = d - 5'd6;
      dsub_res[4*i +: 4] = d[3:0];
      bw = d[4];
    end
  end

  always_comb begin
    if (!dec) begin
      res   = bin_sum[DW-1:0];
      c_out = bin_sum[DW];
      v_out = bin_v;
    end else if (sub) begin
      res   = dsub_res;
      c_out = bin_sum[DW];
      v_out = 1'b0;
    end else begin
      res   = dadd_res;
      c_out = dadd_cy;
      v_out = 1'b0;
    end
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  always_comb begin
    res   = a;
    c_out = c_in;
    unique case (op)
      OP_ASL:  {c_out, res} = {a, 1'b0};
      OP_LSR:  {res, c_out} = {1'b0, a};
      OP_ROL:  {c_out, res} = {a, c_in};
      OP_ROR:  {res, c_out} = {c_in, a};
      default: begin
        res   = a;
        c_out = c_in;
      end
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  logic [DW:0] diff;
  assign diff = {1'b0, a} - {1'b0, m};

  always_comb begin
    c_out = c_in;
    unique case (op)
      OP_AND:  res = a & m;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      OP_INC:  res = a + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:  res = a - {{(DW-1){1'b0}}, 1'b1};
      OP_CMP: begin
        res   = diff[DW-1:0];
        c_out = ~diff[DW];
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_stream_unit.sv
module alu8_stream_unit
  import alu8_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [7:0]   in_reg,
  input  logic [7:0]   in_opnd,
  input  logic         in_c,
  input  logic         in_v,
  input  logic         in_dec,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_result,
  output logic         out_n,
  output logic         out_z,
  output logic         out_c,
  output logic         out_v
);
  alu_op_e       op;
  logic [DW-1:0] ar_res, sh_res, lg_res;
  logic          ar_c, ar_v, sh_c, lg_c;
  logic [DW-1:0] nx_res;
  flags_t        nx_flg;
  logic          fire;
  alu_op_e       out_op;

  assign op = alu_op_e'(in_op);

  alu8_arith u_arith (
    .a(in_reg), .m(in_opnd), .c_in(in_c), .dec(in_dec),
    .sub(op == OP_SUB), .res(ar_res), .c_out(ar_c), .v_out(ar_v)
  );

  alu8_shift u_shift (
    .op(op), .a(in_reg), .c_in(in_c), .res(sh_res), .c_out(sh_c)
  );

  alu8_logic u_logic (
    .op(op), .a(in_reg), .m(in_opnd), .c_in(in_c), .res(lg_res), .c_out(lg_c)
  );

  always_comb begin
    nx_flg.v = in_v;
    unique case (op)
      OP_ADD, OP_SUB: begin
        nx_res   = ar_res;
        nx_flg.c = ar_c;
        nx_flg.v = ar_v;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        nx_res   = sh_res;
        nx_flg.c = sh_c;
      end
      OP_BIT: begin
        nx_res   = in_reg;
        nx_flg.c = in_c;
        nx_flg.v = in_opnd[DW-2];
      end
      default: begin
        nx_res   = lg_res;
        nx_flg.c = lg_c;
      end
    endcase
    if (op == OP_BIT) begin
      nx_flg.n = in_opnd[DW-1];
      nx_flg.z = ((in_reg & in_opnd) == '0);
    end else begin
      nx_flg.n = nx_res[DW-1];
      nx_flg.z = (nx_res == '0);
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      {out_n, out_z, out_c, out_v} <= '0;
      out_op     <= OP_ADD;
    end else begin
      if (fire) begin
        out_valid  <= 1'b1;
        out_result <= nx_res;
        {out_n, out_z, out_c, out_v} <= nx_flg;
        out_op     <= op;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R1: N/Z follow the registered result except for bit test
  assert_nz_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op != OP_BIT) |-> (out_n == out_result[7] && out_z == (out_result == 8'd0)));

  // R2: stalled output holds
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_c)));

  // R10: decimal add/subtract never report overflow
  assert_dec_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_dec && (op == OP_ADD || op == OP_SUB)) |=> !out_v);

  // R5: shift left carries out old bit 7
  assert_asl_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_ASL) |=> (out_c == $past(in_reg[7])));

  // R6: bit test keeps the register and copies operand bit 6 to V
  assert_bit_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_BIT) |=> (out_result == $past(in_reg) && out_v == $past(in_opnd[6])));

  // R7: compare carry is unsigned greater-or-equal
  assert_cmp_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_CMP) |=> (out_c == ($past(in_reg) >= $past(in_opnd))));
endmodule

// File: tb/alu8_stream_unit_tb_top.sv
`timescale 1ns/1ps
module alu8_stream_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'd0;
  logic [7:0] in_reg = 8'd0;
  logic [7:0] in_opnd = 8'd0;
  logic       in_c = 1'b0;
  logic       in_v = 1'b0;
  logic       in_dec = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic       out_n, out_z, out_c, out_v;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  alu8_stream_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_reg(in_reg), .in_opnd(in_opnd), .in_c(in_c),
    .in_v(in_v), .in_dec(in_dec), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_v(out_v)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // expected {result, n, z, c, v}
  function automatic logic [11:0] ref_model(int op, int a, int m, int c, int v, int d);
    int r, n_, z_, c_, v_, t, lo, hi;
    c_ = c; v_ = v; r = a;
    case (op)
      0: if (d != 0) begin
           lo = (a & 15) + (m & 15) + c;
           if (lo > 9) lo += 6;
           hi = (a >> 4) + (m >> 4) + ((lo > 15) ? 1 : 0);
           if (hi > 9) hi += 6;
           c_ = (hi > 15) ? 1 : 0;
           r = ((hi & 15) << 4) | (lo & 15);
           v_ = 0;
         end else begin
           t = a + m + c; r = t & 255; c_ = (t > 255) ? 1 : 0;
           v_ = (((a ^ r) & (m ^ r) & 128) != 0) ? 1 : 0;
         end
      1: if (d != 0) begin
           lo = (a & 15) - (m & 15) - (1 - c);
           if ((lo & 16) != 0) lo -= 6;
           hi = (a >> 4) - (m >> 4) - (((lo & 16) != 0) ? 1 : 0);
           if ((hi & 16) != 0) hi -= 6;
           r = (lo & 15) | ((hi << 4) & 255);
           c_ = ((a - m - (1 - c)) >= 0) ? 1 : 0;
           v_ = 0;
         end else begin
           t = a + (255 - m) + c; r = t & 255; c_ = (t > 255) ? 1 : 0;
           v_ = (((a ^ r) & ((255 - m) ^ r) & 128) != 0) ? 1 : 0;
         end
      2: r = a & m;
      3: r = a | m;
      4: r = a ^ m;
      5: begin r = (a - m) & 255; c_ = (a >= m) ? 1 : 0; end
      6: r = a;
      7: begin c_ = (a >> 7) & 1; r = (a << 1) & 255; end
      8: begin c_ = a & 1; r = a >> 1; end
      9: begin c_ = (a >> 7) & 1; r = ((a << 1) & 255) | c; end
      10: begin c_ = a & 1; r = (a >> 1) | (c << 7); end
      11: r = (a + 1) & 255;
      12: r = (a - 1) & 255;
      default: r = a;
    endcase
    n_ = (r >> 7) & 1;
    z_ = (r == 0) ? 1 : 0;
    if (op == 6) begin
      n_ = (m >> 7) & 1;
      z_ = ((a & m) == 0) ? 1 : 0;
      v_ = (m >> 6) & 1;
    end
    return {r[7:0], n_[0], z_[0], c_[0], v_[0]};
  endfunction

  function automatic string req_of(int op, int d);
    case (op)
      0: return (d != 0) ? "R8" : "R3";
      1: return (d != 0) ? "R9" : "R3";
      2, 3, 4, 13, 14, 15: return "R4";
      5: return "R7";
      6: return "R6";
      7, 8, 9, 10: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(int op, int a, int m, int c, int v, int d);
    logic [11:0] e;
    logic [11:0] got;
    e = ref_model(op, a, m, c, v, d);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = op[3:0]; in_reg = a[7:0]; in_opnd = m[7:0];
    in_c = c[0]; in_v = v[0]; in_dec = d[0];
    @(negedge clk);
    in_valid = 1'b0;
    got = {out_result, out_n, out_z, out_c, out_v};
    check(req_of(op, d), {31'd0, out_valid}, 32'd1);
    check(req_of(op, d), {20'd0, got}, {20'd0, e});
    if (op != 6) check("R1", {30'd0, out_n, out_z}, {30'd0, out_result[7], out_result == 8'd0});
    if (d != 0 && op <= 1) check("R10", {31'd0, out_v}, 32'd0);
  endtask

  initial begin
    logic [11:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});

    // directed corners
    do_op(0, 8'h7F, 8'h01, 0, 0, 0);   // R3 signed overflow
    do_op(0, 8'hFF, 8'h01, 0, 0, 0);   // R3 carry out, zero
    do_op(1, 8'h50, 8'hF0, 1, 0, 0);   // R3 borrow
    do_op(1, 8'h80, 8'h01, 1, 0, 0);   // R3 overflow on subtract
    do_op(0, 8'h58, 8'h46, 1, 1, 1);   // R8 -> 0x05 carry
    do_op(0, 8'h99, 8'h01, 0, 0, 1);   // R8 -> 0x00 carry
    do_op(0, 8'h50, 8'h50, 0, 1, 1);   // R10 V cleared
    do_op(1, 8'h46, 8'h12, 1, 0, 1);   // R9 -> 0x34
    do_op(1, 8'h00, 8'h01, 1, 1, 1);   // R9 -> 0x99, borrow
    do_op(1, 8'h00, 8'h0F, 0, 0, 1);   // R9 non-BCD, borrow drop after fix-up
    do_op(1, 8'h32, 8'h08, 0, 0, 1);   // R9 low borrow into high digit
    do_op(5, 8'h40, 8'h40, 0, 1, 0);   // R7 equal
    do_op(5, 8'h10, 8'h20, 1, 0, 0);   // R7 less
    do_op(6, 8'h0F, 8'hC0, 1, 0, 0);   // R6 zero, N, V
    do_op(7, 8'h81, 8'h00, 0, 1, 0);   // R5
    do_op(8, 8'h01, 8'h00, 0, 0, 0);   // R5
    do_op(9, 8'h80, 8'h00, 1, 0, 0);   // R5
    do_op(10, 8'h01, 8'h00, 1, 0, 0);  // R5
    do_op(11, 8'hFF, 8'h00, 1, 1, 0);  // R11 wrap
    do_op(12, 8'h00, 8'h00, 0, 1, 0);  // R11 wrap
    do_op(2, 8'hF0, 8'h3C, 1, 1, 0);   // R4
    do_op(15, 8'hA5, 8'h00, 0, 1, 0);  // R4 pass-through code

    // R2 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'd3; in_reg = 8'h11; in_opnd = 8'h22; in_c = 0; in_v = 0; in_dec = 0;
    @(negedge clk);
    in_op = 4'd4; in_reg = 8'hFF; in_opnd = 8'hFF;
    check("R2", {31'd0, in_ready}, 32'd0);
    held = {out_result, out_n, out_z, out_c, out_v};
    repeat (3) @(negedge clk);
    check("R2", {20'd0, out_result, out_n, out_z, out_c, out_v}, {20'd0, held});
    check("R2", {24'd0, out_result}, 32'h33);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {24'd0, out_result}, 32'h00);
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);

    // seeded random
    for (int k = 0; k < 600; k++) begin
      int op, d;
      op = int'($urandom_range(0, 15));
      d = int'($urandom_range(0, 1));
      do_op(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), d);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule